// File: doc/BRIEF.md
# Byte Table Lookup Unit

This unit forms a 64-bit result by permuting bytes taken from a small table. The table is made of one to four 64-bit words, packed into a 256-bit input. The 2-bit length field sets how many of those words take part.

Eight index bytes drive the eight result bytes, one index per lane. A lane whose index points inside the table copies the addressed table byte. A lane whose index points past the end of the table takes one of two values, chosen by a mode bit: zero, or the matching byte of a supplied previous destination word.

The unit is used as the data step of a table-lookup vector operation. Register reads and instruction decode happen outside it. A valid strobe marks each operation. The result is registered and appears one cycle later together with an output valid flag.

Top module: `byte_tbl_lookup`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, out_valid is 0 and result is all zeros.
- R2: out_valid is 1 exactly in the cycle after a cycle in which in_valid was 1 at the clock edge, and 0 otherwise. result changes only on an edge where in_valid is 1, and holds its value at every other edge.
- R3: The table length in bytes is (tbl_len + 1) * 8. tbl_len values 0, 1, 2 and 3 give 8, 16, 24 and 32 bytes.
- R4: Result byte i (bits 8i+7..8i) depends only on index byte i (idx_vec bits 8i+7..8i), on dest_old byte i and on the table.
- R5: For an index k below the table length, the result byte is byte (k mod 8) of table word (k div 8). Table word w is tbl_data bits 64w+63..64w. Byte b of a word is its bits 8b+7..8b, so byte 0 is the least significant byte.
- R6: With keep_mode = 0, a lane whose index is at or above the table length gets 0x00.
- R7: With keep_mode = 1, a lane whose index is at or above the table length gets dest_old byte i.
- R8: Indices are unsigned 8-bit values. Any index from 32 to 255 is out of range for every table length.
- R9: Table words at or above word tbl_len + 1 have no effect on the result, whatever their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe; inputs are sampled on this edge |
| tbl_data | input | 256 | Table words, word 0 in the low 64 bits |
| tbl_len | input | 2 | Number of table words minus one |
| idx_vec | input | 64 | Eight byte indices, lane 0 in the low byte |
| dest_old | input | 64 | Previous destination value, used by keep mode |
| keep_mode | input | 1 | 1: out-of-range lanes keep dest_old; 0: they become zero |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Registered lookup result |

## Verification
Each operation presented with in_valid at a rising edge is due on out_valid and result at that same edge, so it can be seen one full cycle after the inputs were driven. An idle edge must leave result unchanged and drop out_valid. The bench drives inputs on the falling edge. Its behavioural model then computes the value due after the next rising edge, and both outputs are compared at the following falling edge. This check runs on every cycle, including idle cycles and reset, so a late, early or spurious update shows up as a mismatch in that cycle.

// File: rtl/byte_tbl_lookup.sv
module byte_tbl_lookup #(
  parameter int LANES = 8,
  parameter int LEN_W = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [(2**LEN_W)*LANES*8-1:0]   tbl_data,
  input  logic [LEN_W-1:0]                tbl_len,
  input  logic [LANES*8-1:0]              idx_vec,
  input  logic [LANES*8-1:0]              dest_old,
  input  logic                            keep_mode,
  output logic                            out_valid,
  output logic [LANES*8-1:0]              result
);
  localparam int WORDS     = 2**LEN_W;
  localparam int VEC_W     = LANES * 8;
  localparam int MAX_BYTES = WORDS * LANES;
  localparam int SEL_W     = $clog2(MAX_BYTES);

  logic [8:0]       limit;
  logic [VEC_W-1:0] nxt;

  assign limit = 9'(({{(9-LEN_W){1'b0}}, tbl_len} + 9'd1) * 9'(LANES));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0]       idx;
    logic             hit;
    logic [SEL_W-1:0] sel;
    logic [7:0]       pick;

    assign idx  = idx_vec[8*i +: 8];
    assign hit  = {1'b0, idx} < limit;
    assign sel  = idx[SEL_W-1:0];
    assign pick = tbl_data[{sel, 3'b000} +: 8];
    assign nxt[8*i +: 8] = hit ? pick : (keep_mode ? dest_old[8*i +: 8] : 8'h00);

    p_zero_oob_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !keep_mode && ({1'b0, idx_vec[8*i +: 8]} >= limit))
        |=> (result[8*i +: 8] == 8'h00));

    p_keep_oob_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && keep_mode && ({1'b0, idx_vec[8*i +: 8]} >= limit))
        |=> (result[8*i +: 8] == $past(dest_old[8*i +: 8])));

    p_high_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !keep_mode && (idx_vec[8*i +: 8] >= 8'(MAX_BYTES)))
        |=> (result[8*i +: 8] == 8'h00));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  always_comb begin
    if (rst_n && out_valid) assert (!$isunknown(result));
  end
endmodule

// File: tb/byte_tbl_lookup_tb.sv
`timescale 1ns/1ps
module byte_tbl_lookup_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] tbl_data = '0;
  logic [1:0]   tbl_len = '0;
  logic [63:0]  idx_vec = '0;
  logic [63:0]  dest_old = '0;
  logic         keep_mode = 1'b0;
  logic         out_valid;
  logic [63:0]  result;

  int n_cmp = 0;
  int n_bad = 0;
  logic        exp_valid = 1'b0;
  logic [63:0] exp_result = '0;

  always #2 clk = ~clk;

  byte_tbl_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tbl_data(tbl_data),
    .tbl_len(tbl_len), .idx_vec(idx_vec), .dest_old(dest_old),
    .keep_mode(keep_mode), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(logic [255:0] t, logic [1:0] ln,
                                        logic [63:0] ix, logic [63:0] d, logic km);
    logic [63:0] r = '0;
    int nbytes = (int'(ln) + 1) * 8;
    for (int i = 0; i < 8; i++) begin
      int k = int'(ix[8*i +: 8]);
      logic [7:0] b;
      if (k < nbytes) begin
        logic [255:0] s = t >> (8 * k);
        b = s[7:0];
      end else if (km) b = d[8*i +: 8];
      else b = 8'h00;
      r[8*i +: 8] = b;
    end
    return r;
  endfunction

  task automatic check(string tag);
    n_cmp++;
    if (out_valid !== exp_valid || result !== exp_result) begin
      n_bad++;
      $display("FAIL %s: valid=%b result=%h expected valid=%b result=%h",
               tag, out_valid, result, exp_valid, exp_result);
    end
  endtask

  task automatic step(logic v, logic [255:0] t, logic [1:0] ln,
                      logic [63:0] ix, logic [63:0] d, logic km, string tag);
    in_valid = v; tbl_data = t; tbl_len = ln; idx_vec = ix; dest_old = d; keep_mode = km;
    @(posedge clk);
    if (rst_n) begin
      exp_valid = v;
      if (v) exp_result = model(t, ln, ix, d, km);
    end else begin
      exp_valid = 1'b0; exp_result = '0;
    end
    @(negedge clk);
    check(tag);
  endtask

  logic [255:0] tbl_a;
  logic [255:0] tbl_b;
  logic [63:0]  r9_first;

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: valid=%b result=%h expected valid=%b result=%h",
             out_valid, result, exp_valid, exp_result);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 32; w++) tbl_a[8*w +: 8] = 8'(8'hA0 + w);
    for (int w = 0; w < 32; w++) tbl_b[8*w +: 8] = 8'(8'h5C ^ (w * 37));
    @(negedge clk);
    step(1'b1, tbl_a, 2'd3, 64'h0706050403020100, '1, 1'b0, "R1 in reset");
    step(1'b0, tbl_a, 2'd3, '0, '0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    step(1'b0, tbl_a, 2'd3, '0, '0, 1'b0, "R1 after reset");
    step(1'b1, tbl_a, 2'd3, 64'h0706050403020100, '0, 1'b0, "R5 identity");
    step(1'b1, tbl_a, 2'd3, 64'h0001020304050607, '0, 1'b0, "R4 reversed lanes");
    step(1'b1, tbl_a, 2'd3, 64'h1F18110A0900081E, '0, 1'b0, "R5 across words");
    step(1'b0, tbl_b, 2'd0, 64'hFFFFFFFFFFFFFFFF, '1, 1'b1, "R2 idle hold");
    step(1'b0, tbl_b, 2'd2, '0, '0, 1'b0, "R2 idle hold");
    step(1'b1, tbl_b, 2'd0, 64'h0807060504030201, '0, 1'b0, "R3 len 8 bytes");
    step(1'b1, tbl_b, 2'd1, 64'h10170F0E08100011, '0, 1'b0, "R3 len 16 bytes");
    step(1'b1, tbl_b, 2'd2, 64'h1718170F19200016, 64'h1122334455667788, 1'b0, "R6 len 24 zeroing");
    step(1'b1, tbl_b, 2'd2, 64'h1718170F19200016, 64'h1122334455667788, 1'b1, "R7 len 24 keeping");
    step(1'b1, tbl_a, 2'd3, 64'hFF80402120100020, 64'hDEADBEEFCAFEF00D, 1'b0, "R8 high zero");
    step(1'b1, tbl_a, 2'd3, 64'hFF80402120100020, 64'hDEADBEEFCAFEF00D, 1'b1, "R8 high keep");
    step(1'b1, tbl_a, 2'd0, 64'h0F0E0D0C0B0A0908, 64'h0123456789ABCDEF, 1'b1, "R7 all out of range");
    r9_first = model(tbl_a, 2'd0, 64'h0710040F0208011F, 64'h0, 1'b0);
    step(1'b1, tbl_a, 2'd0, 64'h0710040F0208011F, 64'h0, 1'b0, "R9 unused words A");
    tbl_b[63:0] = tbl_a[63:0];
    step(1'b1, tbl_b, 2'd0, 64'h0710040F0208011F, 64'h0, 1'b0, "R9 unused words B");
    n_cmp++;
    if (result !== r9_first) begin
      n_bad++;
      $display("FAIL R9: result=%h expected %h", result, r9_first);
    end
    for (int n = 0; n < 60; n++) begin
      logic [255:0] t;
      logic [63:0]  ix;
      for (int w = 0; w < 8; w++) t[32*w +: 32] = $urandom;
      ix = {$urandom, $urandom} & 64'h3F3F3F3F3F3F3F3F;
      step(1'($urandom_range(0, 3) != 0), t, 2'($urandom), ix, {$urandom, $urandom},
           1'($urandom), "R4 R5 random");
    end
    rst_n = 1'b0;
    step(1'b1, tbl_a, 2'd3, 64'h0706050403020100, '0, 1'b0, "R1 second reset");
    rst_n = 1'b1;
    step(1'b0, tbl_a, 2'd3, '0, '0, 1'b0, "R1 after second reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule